// File: doc/BRIEF.md
# Continuously Variable Slope Delta Decoder

This block rebuilds a signed PCM estimate from a one-bit delta-modulated stream. Each time the decoder data strobe fires, it takes one received bit. It then adapts its step size with a run-length (coincidence) rule and moves a leaky integrator up or down by that step. The integrator value is the reconstructed sample. The step adaptation matches the paired encoder bit for bit, so a loopback test reproduces the encoder's integrator sample for sample. The leak pulls the integrator toward zero, so a stream with no net slope settles near mid-scale.

Three control inputs change the behaviour:
- An algorithm select picks a three-bit or a four-bit coincidence rule.
- An active-low force-idle input replaces the received bits with an internal alternating pattern, which drives the output to mid-scale.
- An active-low powersave input stops the decoder, marks its output as not driven and returns its state to the reset values.

The analog reconstruction filter and the output buffer sit outside this block.

Top module: `cvsd_dec_top`

## Requirements
- R1: After reset, `sample` is 0, `sampleValid` is 0, `outDriven` is 1 and the step is STEP_MIN (16), so the first received 1 gives a sample of +16.
- R2: For each accepted bit, the integrator first loses its arithmetic right shift by LEAK_SHIFT (5), rounding toward minus infinity. It then gains the step for a 1 bit or loses the step for a 0 bit.
- R3: A bit is coincident when the current bit and the bits just before it form a run of equal bits at least 3 long (`algo3`=1) or 4 long (`algo3`=0). A coincident bit raises the step by STEP_INC (256), up to a ceiling of STEP_MAX (4096). Any other bit lowers the step by its own right shift by DECAY_SHIFT (4), down to a floor of STEP_MIN. The new step is the one applied to that same bit.
- R4: The integrator saturates at +32767 and -32768 and never wraps.
- R5: `sampleValid` is high for exactly one clock, in the cycle after the one in which `bitStrobe` was sampled high. The updated `sample` is present in that same cycle.
- R6: While `idleN` is 0, `bitIn` has no effect. The decoder uses an internal sequence 0,1,0,1,... that starts at 0 on the first strobe after `idleN` goes low. The output then settles to within one minimum step of zero.
- R7: While `powerN` is 0, strobes are ignored, `sampleValid` stays 0, `outDriven` is 0 and `sample` reads 0. When `powerN` returns to 1, the decoder behaves as it does after reset.
- R8: Between strobes, `sample` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| bitIn | input | 1 | Received serial bit |
| bitStrobe | input | 1 | One-clock pulse marking a new received bit |
| algo3 | input | 1 | 1 selects the three-bit coincidence rule, 0 selects the four-bit rule |
| idleN | input | 1 | Active-low force idle |
| powerN | input | 1 | Active-low powersave |
| sample | output | SAMPLE_W (16) | Signed reconstructed sample |
| sampleValid | output | 1 | Pulses once per processed bit |
| outDriven | output | 1 | High while the output is active |

## Verification
A wrong step or a wrong run count corrupts the integrator on the next bit, so the mismatch appears at `sample` in the valid cycle of the very bit that went wrong. Because of the leak, the error then fades over a few tens of bits. The bench therefore compares every valid sample against a reference model rather than only end values. A broken idle sequence or a broken powersave clear shows within one bit: in the first case the sample moves away from the alternating path, in the second the first bit after restore differs from +16.

// File: rtl/cvsd_dec_pkg.sv
package cvsd_dec_pkg;
  typedef struct packed {
    logic adv;       // accept one bit this cycle
    logic clr;       // return datapath state to reset values
    logic bitVal;    // effective bit after idle substitution
    logic coincide;  // run-length rule met
    logic drive;     // output active
  } decStrobe_t;
endpackage

// File: rtl/cvsd_dec_ctrl.sv
module cvsd_dec_ctrl
  import cvsd_dec_pkg::*;
#(
  parameter int RUN_MAX = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitIn,
  input  logic       bitStrobe,
  input  logic       algo3,
  input  logic       idleN,
  input  logic       powerN,
  output decStrobe_t strb
);
  localparam int RW = $clog2(RUN_MAX + 1);
  localparam logic [RW-1:0] RUN_TOP = RW'(RUN_MAX);
  localparam logic [RW-1:0] THR3 = RW'(3);
  localparam logic [RW-1:0] THR4 = RW'(4);

  logic [RW-1:0] runLen, runNext, thresh;
  logic lastBit, phase, effBit;

  always_comb begin
    effBit = idleN ? bitIn : phase;
    if (runLen != '0 && lastBit == effBit)
      runNext = (runLen == RUN_TOP) ? RUN_TOP : runLen + RW'(1);
    else
      runNext = RW'(1);
    thresh = algo3 ? THR3 : THR4;
    strb.adv      = bitStrobe & powerN;
    strb.clr      = ~powerN;
    strb.bitVal   = effBit;
    strb.coincide = (runNext >= thresh);
    strb.drive    = powerN;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !powerN) begin
      runLen  <= '0;
      lastBit <= 1'b0;
      phase   <= 1'b0;
    end else begin
      if (bitStrobe) begin
        runLen  <= runNext;
        lastBit <= effBit;
      end
      if (idleN)          phase <= 1'b0;
      else if (bitStrobe) phase <= ~phase;
    end
  end

  // Back-to-back idle strobes alternate, so the run never grows.
  assert_idle_alternate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && !idleN && $past(strb.adv && !idleN && rstN)) |-> (runNext == RW'(1)));

  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= RUN_TOP);
endmodule

// File: rtl/cvsd_dec_dp.sv
module cvsd_dec_dp
  import cvsd_dec_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int STEP_MIN    = 16,
  parameter int STEP_MAX    = 4096,
  parameter int STEP_INC    = 256,
  parameter int DECAY_SHIFT = 4,
  parameter int LEAK_SHIFT  = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  decStrobe_t                 strb,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       sampleValid
);
  localparam int WIDE = SAMPLE_W + 2;
  localparam logic [SAMPLE_W-1:0] MIN_S = SAMPLE_W'(STEP_MIN);
  localparam logic [SAMPLE_W-1:0] MAX_S = SAMPLE_W'(STEP_MAX);
  localparam logic [SAMPLE_W:0]   INC_W = (SAMPLE_W+1)'(STEP_INC);
  localparam logic [SAMPLE_W:0]   MAX_W = (SAMPLE_W+1)'(STEP_MAX);
  localparam logic signed [WIDE-1:0] SAT_HI = WIDE'((2**(SAMPLE_W-1)) - 1);
  localparam logic signed [WIDE-1:0] SAT_LO = -SAT_HI - WIDE'(1);

  logic [SAMPLE_W-1:0] step, stepNext, shrunk;
  logic [SAMPLE_W:0]   grown;
  logic signed [SAMPLE_W-1:0] acc, accNext;
  logic signed [WIDE-1:0] accExt, leaked, stepExt, sum;
  logic validQ;

  always_comb begin
    grown  = {1'b0, step} + INC_W;
    shrunk = step - (step >> DECAY_SHIFT);
    if (strb.coincide)
      stepNext = (grown > MAX_W) ? MAX_S : grown[SAMPLE_W-1:0];
    else
      stepNext = (shrunk < MIN_S) ? MIN_S : shrunk;
    accExt  = WIDE'(acc);
    leaked  = accExt - (accExt >>> LEAK_SHIFT);
    stepExt = signed'({2'b00, stepNext});
    sum     = strb.bitVal ? (leaked + stepExt) : (leaked - stepExt);
    if (sum > SAT_HI)      accNext = SAT_HI[SAMPLE_W-1:0];
    else if (sum < SAT_LO) accNext = SAT_LO[SAMPLE_W-1:0];
    else                   accNext = sum[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clr) begin
      step   <= MIN_S;
      acc    <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.adv;
      if (strb.adv) begin
        step <= stepNext;
        acc  <= accNext;
      end
    end
  end

  assign sample      = strb.drive ? acc : '0;
  assign sampleValid = validQ;

  assert_step_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (step >= MIN_S) && (step <= MAX_S));

  assert_step_grow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && strb.coincide) |=> (step >= $past(step)));

  assert_step_shrink_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.adv && !strb.coincide) |=> (step <= $past(step)));

  assert_power_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (step == MIN_S && acc == '0 && !validQ));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.adv && !strb.clr) |=> $stable(acc));
endmodule

// File: rtl/cvsd_dec_top.sv
module cvsd_dec_top
  import cvsd_dec_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int STEP_MIN    = 16,
  parameter int STEP_MAX    = 4096,
  parameter int STEP_INC    = 256,
  parameter int DECAY_SHIFT = 4,
  parameter int LEAK_SHIFT  = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       bitIn,
  input  logic                       bitStrobe,
  input  logic                       algo3,
  input  logic                       idleN,
  input  logic                       powerN,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       sampleValid,
  output logic                       outDriven
);
  decStrobe_t strb;

  cvsd_dec_ctrl #(.RUN_MAX(4)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitStrobe(bitStrobe),
    .algo3(algo3), .idleN(idleN), .powerN(powerN), .strb(strb)
  );

  cvsd_dec_dp #(
    .SAMPLE_W(SAMPLE_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
    .STEP_INC(STEP_INC), .DECAY_SHIFT(DECAY_SHIFT), .LEAK_SHIFT(LEAK_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sample(sample), .sampleValid(sampleValid)
  );

  assign outDriven = strb.drive;

  assert_valid_driven_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> outDriven);
endmodule

// File: tb/tb_cvsd_dec_top.sv
module tb_cvsd_dec_top;
  logic clk = 1'b0;
  logic rstN = 1'b0, bitIn = 1'b0, bitStrobe = 1'b0, algo3 = 1'b1, idleN = 1'b1, powerN = 1'b1;
  logic signed [15:0] sample;
  logic sampleValid, outDriven;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cvsd_dec_top dut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitStrobe(bitStrobe), .algo3(algo3),
    .idleN(idleN), .powerN(powerN), .sample(sample), .sampleValid(sampleValid),
    .outDriven(outDriven)
  );

  // Reference model built from the requirements
  int mAcc, mStep, mRun, mLast, mPhase;

  task automatic modelReset();
    mAcc = 0; mStep = 16; mRun = 0; mLast = 0; mPhase = 0;
  endtask

  task automatic modelBit(input int b, input int a3, input int idl);
    int eff, run;
    if (idl != 0) mPhase = 0;
    eff = (idl != 0) ? b : mPhase;
    if (idl == 0) mPhase = 1 - mPhase;
    run = (mRun != 0 && mLast == eff) ? ((mRun + 1 > 4) ? 4 : mRun + 1) : 1;
    if (run >= ((a3 != 0) ? 3 : 4)) begin
      mStep = mStep + 256;
      if (mStep > 4096) mStep = 4096;
    end else begin
      mStep = mStep - (mStep >> 4);
      if (mStep < 16) mStep = 16;
    end
    mAcc = mAcc - (mAcc >>> 5) + ((eff != 0) ? mStep : -mStep);
    if (mAcc > 32767) mAcc = 32767;
    if (mAcc < -32768) mAcc = -32768;
    mRun = run; mLast = eff;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input string req);
    @(negedge clk);
    bitIn = b; bitStrobe = 1'b1;
    modelBit(int'(b), int'(algo3), int'(idleN));
    @(negedge clk);
    bitStrobe = 1'b0;
    check({req, " valid"}, int'(sampleValid), 1);
    check({req, " sample"}, int'(sample), mAcc);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  typedef struct packed { logic b; int exp; } vec_t;
  localparam vec_t VECS [7] = '{
    '{1'b1, 16}, '{1'b1, 32}, '{1'b1, 303}, '{1'b1, 822},
    '{1'b0, 302}, '{1'b0, -172}, '{1'b0, -887}
  };

  initial begin
    logic [15:0] lfsr;
    logic signed [15:0] held;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sample", int'(sample), 0);
    check("R1 valid", int'(sampleValid), 0);
    check("R1 driven", int'(outDriven), 1);

    // Table walk, three-bit rule from reset: R2 R3 R5
    algo3 = 1'b1;
    foreach (VECS[i]) begin
      @(negedge clk);
      bitIn = VECS[i].b; bitStrobe = 1'b1;
      modelBit(int'(VECS[i].b), 1, 1);
      @(negedge clk);
      bitStrobe = 1'b0;
      check("R5 valid pulse", int'(sampleValid), 1);
      check("R2 R3 table sample", int'(sample), VECS[i].exp);
      @(negedge clk);
      check("R5 valid single", int'(sampleValid), 0);
    end

    // R8 hold between strobes
    held = sample;
    repeat (6) @(negedge clk);
    check("R8 hold", int'(sample), int'(held));

    // R3 four-bit rule: third equal bit is not coincident
    doReset();
    algo3 = 1'b0;
    sendBit(1'b1, "R3 algo4");
    sendBit(1'b1, "R3 algo4");
    sendBit(1'b1, "R3 algo4");
    check("R3 algo4 third bit", int'(sample), 47);
    sendBit(1'b1, "R3 algo4");

    // R2 R3 pseudo-random stream, rule flipping
    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (k % 50 == 0) algo3 = ~algo3;
      sendBit((k % 7 < 4) ? lfsr[0] : lfsr[3], "R2 R3 stream");
    end

    // R4 saturation both ways
    algo3 = 1'b1;
    for (int k = 0; k < 80; k++) sendBit(1'b1, "R4 up");
    check("R4 positive limit", int'(sample), 32767);
    for (int k = 0; k < 120; k++) sendBit(1'b0, "R4 down");
    check("R4 negative limit", int'(sample), -32768);

    // R6 force idle ignores bitIn and settles near zero
    idleN = 1'b0;
    for (int k = 0; k < 400; k++) sendBit(1'b1, "R6 idle");
    check("R6 near zero", int'((sample <= 16 && sample >= -16) ? 1 : 0), 1);
    idleN = 1'b1;

    // R7 powersave
    sendBit(1'b1, "R7 pre");
    @(negedge clk);
    powerN = 1'b0;
    @(negedge clk);
    check("R7 not driven", int'(outDriven), 0);
    check("R7 sample zero", int'(sample), 0);
    bitStrobe = 1'b1; bitIn = 1'b1;
    @(negedge clk);
    bitStrobe = 1'b0;
    check("R7 no valid", int'(sampleValid), 0);
    @(negedge clk);
    powerN = 1'b1;
    modelReset();
    @(negedge clk);
    check("R7 restored driven", int'(outDriven), 1);
    sendBit(1'b1, "R7 restart");
    check("R7 first bit", int'(sample), 16);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule